// File: doc/BRIEF.md
# Vector Pipeline Issue Controller

This block sequences one vector instruction at a time into a functional unit whose latency is fixed for each opcode. When a start strobe arrives while the block is idle, it captures the opcode, the requested element count and the per-element write-enable mask. It then issues element indices on consecutive cycles. A shift chain of valid tokens models the unit's pipeline, so once the pipe is full one element retires every cycle.

Each retiring element produces a writeback strobe with its index, unless its mask bit is clear. One cycle before an element's writeback slot, a forward strobe carries the same index. A dependent vector operation can use it to chain behind this one element by element, without waiting for the whole vector. Busy covers the whole operation, and a one-cycle done pulse marks its end. The arithmetic itself and the memory system sit outside this block.

Top module: `vec_issue_ctrl`

## Requirements
- R1: A start strobe sampled while idle with a nonzero length raises busy in the next cycle and issues element 0 in that same cycle.
- R2: Element k (k = 0..n-1) is issued exactly k cycles after element 0, one element per cycle with no gaps.
- R3: Element k reaches its writeback slot a fixed number of cycles after its issue: 6 for opcode 0 (add), 6 for opcode 1 (multiply), 20 for opcode 2 (divide) and 12 for opcode 3 (load).
- R4: Once the first result has arrived, writeback slots follow on consecutive cycles in index order, one per cycle.
- R5: Mask bit k (bit 0 belongs to element 0) gates element k's writeback: 1 produces the writeback strobe, 0 suppresses it. Mask bits at or above the element count have no effect.
- R6: For every issued element, masked or not, a forward strobe with the element's index appears one cycle before that element's writeback slot.
- R7: A length value above the maximum vector length (parameter, default 64) is clamped, so exactly the maximum number of elements is issued.
- R8: A length of zero issues nothing, writes back nothing, leaves busy low and pulses done in the next cycle.
- R9: Busy stays high until the cycle after the last element's writeback slot. In that cycle busy is low and done is high for exactly one cycle.
- R10: A start strobe sampled while busy is ignored. The running operation's issue, writeback and completion timing are unchanged.
- R11: Synchronous reset clears every output and flushes all elements in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for a new vector instruction |
| op_i | input | 2 | Opcode: 0 add, 1 multiply, 2 divide, 3 load |
| vlen_i | input | 7 | Requested element count (clamped to the maximum) |
| mask_i | input | 64 | Per-element writeback enable, bit k for element k |
| iss_vld_o | output | 1 | An element enters the unit this cycle |
| iss_idx_o | output | 6 | Index of the issued element |
| fwd_vld_o | output | 1 | Early-forward strobe: the result is ready next cycle |
| fwd_idx_o | output | 6 | Index of the forwarded element |
| wb_vld_o | output | 1 | Writeback strobe for an unmasked element |
| wb_idx_o | output | 6 | Index of the written-back element |
| busy_o | output | 1 | An instruction is in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that reset is held for at least two cycles, so that no property compares values across a flushed pipe. They also assume that opcode, length and mask matter only in the cycle where a start is accepted. The bench changes those inputs only together with a start strobe, and it holds every reset for several cycles. Starts that land while the block is busy deliberately carry a different opcode and length, so that an ignored start would show up in the timing.

// File: rtl/vi_pkg.sv
package vi_pkg;

  typedef enum logic [1:0] {
    VOP_ADD  = 2'd0,
    VOP_MUL  = 2'd1,
    VOP_DIV  = 2'd2,
    VOP_LOAD = 2'd3
  } vop_e;

  function automatic int lat_pick(vop_e op, int l_add, int l_mul, int l_div, int l_ld);
    case (op)
      VOP_ADD: return l_add;
      VOP_MUL: return l_mul;
      VOP_DIV: return l_div;
      default: return l_ld;
    endcase
  endfunction

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/vi_issue_seq.sv
module vi_issue_seq #(
  parameter int MAX_VL = 64,
  parameter int LEN_W  = 7,
  parameter int IDX_W  = 6,
  parameter int DEPTH  = 20,
  parameter int PW     = 5,
  parameter int L_ADD  = 6,
  parameter int L_MUL  = 6,
  parameter int L_DIV  = 20,
  parameter int L_LD   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [LEN_W-1:0]  vlen_i,
  input  logic [MAX_VL-1:0] mask_i,
  input  logic              last_retired_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              iss_vld_o,
  output logic [IDX_W-1:0]  iss_idx_o,
  output logic              ins_vld_o,
  output logic [PW-1:0]     ins_pos_o,
  output logic [IDX_W+1:0]  ins_tok_o
);
  import vi_pkg::*;

  logic [LEN_W-1:0]  n_in, n_q, cnt_q, cnt_nx;
  logic [MAX_VL-1:0] mask_q;
  logic [PW-1:0]     pos_q, pos_new;
  logic              issuing_q, accept, go;
  logic              nxt_msk, nxt_last;
  logic [IDX_W-1:0]  nxt_idx;
  int                lat_sel;

  always_comb begin
    n_in    = (vlen_i > LEN_W'(MAX_VL)) ? LEN_W'(MAX_VL) : vlen_i;
    accept  = start_i & ~busy_o;
    go      = accept & (n_in != '0);
    lat_sel = lat_pick(vop_e'(op_i), L_ADD, L_MUL, L_DIV, L_LD);
    pos_new = PW'(DEPTH - lat_sel);
    cnt_nx  = cnt_q + LEN_W'(1);
    ins_vld_o = 1'b0;
    nxt_idx   = '0;
    nxt_msk   = 1'b0;
    nxt_last  = 1'b0;
    ins_pos_o = pos_q;
    if (go) begin
      ins_vld_o = 1'b1;
      nxt_msk   = mask_i[0];
      nxt_last  = (n_in == LEN_W'(1));
      ins_pos_o = pos_new;
    end else if (issuing_q) begin
      ins_vld_o = 1'b1;
      nxt_idx   = cnt_q[IDX_W-1:0];
      nxt_msk   = mask_q[cnt_q[IDX_W-1:0]];
      nxt_last  = (cnt_nx == n_q);
    end
    ins_tok_o = {nxt_last, nxt_msk, nxt_idx};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      iss_vld_o <= 1'b0;
      iss_idx_o <= '0;
      issuing_q <= 1'b0;
      cnt_q     <= '0;
      n_q       <= '0;
      mask_q    <= '0;
      pos_q     <= '0;
    end else begin
      iss_vld_o <= ins_vld_o;
      iss_idx_o <= nxt_idx;
      done_o    <= (accept & (n_in == '0)) | last_retired_i;
      if (go) begin
        busy_o    <= 1'b1;
        n_q       <= n_in;
        mask_q    <= mask_i;
        pos_q     <= pos_new;
        cnt_q     <= LEN_W'(1);
        issuing_q <= (n_in != LEN_W'(1));
      end else begin
        if (issuing_q) begin
          cnt_q     <= cnt_nx;
          issuing_q <= (cnt_nx != n_q);
        end
        if (last_retired_i) busy_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vi_valid_chain.sv
module vi_valid_chain #(
  parameter int DEPTH = 20,
  parameter int PW    = 5,
  parameter int IDX_W = 6,
  localparam int TW   = IDX_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_vld_i,
  input  logic [PW-1:0]    ins_pos_i,
  input  logic [TW-1:0]    ins_tok_i,
  output logic             tail_vld_o,
  output logic [TW-1:0]    tail_tok_o,
  output logic             pen_vld_o,
  output logic [IDX_W-1:0] pen_idx_o
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic          s_vld;
    logic [TW-1:0] s_tok;
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          s_vld <= 1'b0;
          s_tok <= '0;
        end else if (ins_vld_i && ins_pos_i == PW'(i)) begin
          s_vld <= 1'b1;
          s_tok <= ins_tok_i;
        end else begin
          s_vld <= 1'b0;
          s_tok <= '0;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) begin
          s_vld <= 1'b0;
          s_tok <= '0;
        end else if (ins_vld_i && ins_pos_i == PW'(i)) begin
          s_vld <= 1'b1;
          s_tok <= ins_tok_i;
        end else begin
          s_vld <= g_stage[i-1].s_vld;
          s_tok <= g_stage[i-1].s_tok;
        end
      end
    end
  end

  assign tail_vld_o = g_stage[DEPTH-1].s_vld;
  assign tail_tok_o = g_stage[DEPTH-1].s_tok;
  assign pen_vld_o  = g_stage[DEPTH-2].s_vld;
  assign pen_idx_o  = g_stage[DEPTH-2].s_tok[IDX_W-1:0];

endmodule

// File: rtl/vi_retire.sv
module vi_retire #(
  parameter int IDX_W = 6,
  localparam int TW   = IDX_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tail_vld_i,
  input  logic [TW-1:0]    tail_tok_i,
  input  logic             pen_vld_i,
  input  logic [IDX_W-1:0] pen_idx_i,
  output logic             wb_vld_o,
  output logic [IDX_W-1:0] wb_idx_o,
  output logic             fwd_vld_o,
  output logic [IDX_W-1:0] fwd_idx_o,
  output logic             last_retired_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_vld_o       <= 1'b0;
      wb_idx_o       <= '0;
      fwd_vld_o      <= 1'b0;
      fwd_idx_o      <= '0;
      last_retired_o <= 1'b0;
    end else begin
      wb_vld_o       <= tail_vld_i & tail_tok_i[IDX_W];
      wb_idx_o       <= tail_tok_i[IDX_W-1:0];
      last_retired_o <= tail_vld_i & tail_tok_i[IDX_W+1];
      fwd_vld_o      <= pen_vld_i;
      fwd_idx_o      <= pen_idx_i;
    end
  end

endmodule

// File: rtl/vec_issue_ctrl.sv
module vec_issue_ctrl #(
  parameter int MAX_VL = 64,
  parameter int L_ADD  = 6,
  parameter int L_MUL  = 6,
  parameter int L_DIV  = 20,
  parameter int L_LD   = 12,
  localparam int LEN_W = $clog2(MAX_VL + 1),
  localparam int IDX_W = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [LEN_W-1:0]  vlen_i,
  input  logic [MAX_VL-1:0] mask_i,
  output logic              iss_vld_o,
  output logic [IDX_W-1:0]  iss_idx_o,
  output logic              fwd_vld_o,
  output logic [IDX_W-1:0]  fwd_idx_o,
  output logic              wb_vld_o,
  output logic [IDX_W-1:0]  wb_idx_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int DEPTH = vi_pkg::max4(L_ADD, L_MUL, L_DIV, L_LD);
  localparam int PW    = $clog2(DEPTH);
  localparam int TW    = IDX_W + 2;

  logic             ins_vld, tail_vld, pen_vld, last_ret;
  logic [PW-1:0]    ins_pos;
  logic [TW-1:0]    ins_tok, tail_tok;
  logic [IDX_W-1:0] pen_idx;

  vi_issue_seq #(
    .MAX_VL(MAX_VL), .LEN_W(LEN_W), .IDX_W(IDX_W), .DEPTH(DEPTH), .PW(PW),
    .L_ADD(L_ADD), .L_MUL(L_MUL), .L_DIV(L_DIV), .L_LD(L_LD)
  ) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .vlen_i(vlen_i),
    .mask_i(mask_i), .last_retired_i(last_ret), .busy_o(busy_o), .done_o(done_o),
    .iss_vld_o(iss_vld_o), .iss_idx_o(iss_idx_o), .ins_vld_o(ins_vld),
    .ins_pos_o(ins_pos), .ins_tok_o(ins_tok)
  );

  vi_valid_chain #(.DEPTH(DEPTH), .PW(PW), .IDX_W(IDX_W)) u_chain (
    .clk(clk), .rst(rst), .ins_vld_i(ins_vld), .ins_pos_i(ins_pos),
    .ins_tok_i(ins_tok), .tail_vld_o(tail_vld), .tail_tok_o(tail_tok),
    .pen_vld_o(pen_vld), .pen_idx_o(pen_idx)
  );

  vi_retire #(.IDX_W(IDX_W)) u_ret (
    .clk(clk), .rst(rst), .tail_vld_i(tail_vld), .tail_tok_i(tail_tok),
    .pen_vld_i(pen_vld), .pen_idx_i(pen_idx), .wb_vld_o(wb_vld_o),
    .wb_idx_o(wb_idx_o), .fwd_vld_o(fwd_vld_o), .fwd_idx_o(fwd_idx_o),
    .last_retired_o(last_ret)
  );

endmodule

// File: rtl/vi_chk.sv
module vi_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             iss_vld_o,
  input logic [IDX_W-1:0] iss_idx_o,
  input logic             fwd_vld_o,
  input logic [IDX_W-1:0] fwd_idx_o,
  input logic             wb_vld_o,
  input logic [IDX_W-1:0] wb_idx_o,
  input logic             busy_o,
  input logic             done_o
);

  assert_first_issue_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (iss_vld_o && iss_idx_o == '0));

  assert_issue_in_busy_R2: assert property (@(posedge clk) disable iff (rst)
    iss_vld_o |-> busy_o);

  assert_issue_step_R2: assert property (@(posedge clk) disable iff (rst)
    (iss_vld_o && $past(iss_vld_o)) |-> (iss_idx_o == $past(iss_idx_o) + IDX_W'(1)));

  assert_wb_in_busy_R3: assert property (@(posedge clk) disable iff (rst)
    wb_vld_o |-> busy_o);

  assert_fwd_leads_wb_R6: assert property (@(posedge clk) disable iff (rst)
    wb_vld_o |-> ($past(fwd_vld_o) && wb_idx_o == $past(fwd_idx_o)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  assert_busy_end_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

endmodule

bind vec_issue_ctrl vi_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .iss_vld_o(iss_vld_o), .iss_idx_o(iss_idx_o),
  .fwd_vld_o(fwd_vld_o), .fwd_idx_o(fwd_idx_o), .wb_vld_o(wb_vld_o),
  .wb_idx_o(wb_idx_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/vec_issue_ctrl_tb.sv
module vec_issue_ctrl_tb;

  typedef struct packed {
    logic [1:0]  op;
    logic [6:0]  len;
    logic [63:0] mask;
    logic [7:0]  ign;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 7'd8,   {64{1'b1}},              8'hFF},
    '{2'd1, 7'd5,   64'h0000_0000_0000_0015, 8'hFF},
    '{2'd2, 7'd3,   {64{1'b1}},              8'hFF},
    '{2'd3, 7'd4,   64'hFFFF_0000_0000_000A, 8'hFF},
    '{2'd0, 7'd100, 64'hF0F0_F0F0_F0F0_F0F0, 8'hFF},
    '{2'd1, 7'd64,  {64{1'b1}},              8'hFF},
    '{2'd0, 7'd0,   {64{1'b1}},              8'hFF},
    '{2'd2, 7'd6,   {64{1'b1}},              8'd2},
    '{2'd3, 7'd1,   64'h0,                   8'hFF}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'd0;
  logic [6:0]  vlen_i = 7'd0;
  logic [63:0] mask_i = 64'd0;
  logic        iss_vld_o, fwd_vld_o, wb_vld_o, busy_o, done_o;
  logic [5:0]  iss_idx_o, fwd_idx_o, wb_idx_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  vec_issue_ctrl u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .vlen_i(vlen_i),
    .mask_i(mask_i), .iss_vld_o(iss_vld_o), .iss_idx_o(iss_idx_o),
    .fwd_vld_o(fwd_vld_o), .fwd_idx_o(fwd_idx_o), .wb_vld_o(wb_vld_o),
    .wb_idx_o(wb_idx_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input string detail);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: %s", req, detail);
    end
  endtask

  function automatic int lat_of(input logic [1:0] op);
    case (op)
      2'd0: return 6;
      2'd1: return 6;
      2'd2: return 20;
      default: return 12;
    endcase
  endfunction

  task automatic run_vec(input vec_t v, input int vi);
    int n, lat, last_t, done_t, n_iss;
    int e_iss = 0, e_wb = 0, e_fwd = 0, e_busy = 0, e_done = 0;
    string m_iss = "", m_wb = "", m_fwd = "", m_busy = "", m_done = "";
    string tag;
    n      = (v.len > 7'd64) ? 64 : int'(v.len);
    lat    = lat_of(v.op);
    done_t = (n == 0) ? 0 : n + lat;
    last_t = done_t + 3;
    n_iss  = 0;
    tag    = (v.len > 7'd64) ? "R7" : (v.len == 0) ? "R8" : (v.ign != 8'hFF) ? "R10" : "R2";
    op_i = v.op; vlen_i = v.len; mask_i = v.mask; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int t = 0; t <= last_t; t++) begin
      bit x_iss, x_wb, x_fwd, x_busy, x_done;
      int k;
      x_iss = (t < n);
      k = t - lat;
      x_wb = 1'b0;
      if (k >= 0 && k < n) x_wb = v.mask[k];
      x_fwd  = (k + 1 >= 0) && (k + 1 < n);
      x_busy = (n > 0) && (t < done_t);
      x_done = (t == done_t);
      if (iss_vld_o) n_iss++;
      if (iss_vld_o !== x_iss || (x_iss && iss_idx_o !== 6'(t))) begin
        if (e_iss == 0) m_iss = $sformatf("t=%0d iss=%0b/%0d expected %0b/%0d", t, iss_vld_o, iss_idx_o, x_iss, t);
        e_iss++;
      end
      if (wb_vld_o !== x_wb || (x_wb && wb_idx_o !== 6'(k))) begin
        if (e_wb == 0) m_wb = $sformatf("t=%0d wb=%0b/%0d expected %0b/%0d", t, wb_vld_o, wb_idx_o, x_wb, k);
        e_wb++;
      end
      if (fwd_vld_o !== x_fwd || (x_fwd && fwd_idx_o !== 6'(k + 1))) begin
        if (e_fwd == 0) m_fwd = $sformatf("t=%0d fwd=%0b/%0d expected %0b/%0d", t, fwd_vld_o, fwd_idx_o, x_fwd, k + 1);
        e_fwd++;
      end
      if (busy_o !== x_busy) begin
        if (e_busy == 0) m_busy = $sformatf("t=%0d busy=%0b expected %0b", t, busy_o, x_busy);
        e_busy++;
      end
      if (done_o !== x_done) begin
        if (e_done == 0) m_done = $sformatf("t=%0d done=%0b expected %0b", t, done_o, x_done);
        e_done++;
      end
      if (t == int'(v.ign)) begin
        op_i = 2'd0; vlen_i = 7'd3; mask_i = 64'h0; start_i = 1'b1;
      end
      @(negedge clk);
      start_i = 1'b0; op_i = v.op; vlen_i = v.len; mask_i = v.mask;
    end
    // R1 R2: issue timing and index order
    check(e_iss == 0, $sformatf("R1 R2 vec%0d", vi), m_iss);
    // R3 R4 R5: writeback slot, throughput and masking
    check(e_wb == 0, $sformatf("R3 R4 R5 vec%0d", vi), m_wb);
    // R6: early forward one cycle ahead of writeback
    check(e_fwd == 0, $sformatf("R6 vec%0d", vi), m_fwd);
    // R9: busy window
    check(e_busy == 0, $sformatf("R9 vec%0d", vi), m_busy);
    // R9 R8: done pulse
    check(e_done == 0, $sformatf("R9 R8 vec%0d", vi), m_done);
    // R7 R8 R10: element count issued
    check(n_iss == n, $sformatf("%s vec%0d", tag, vi),
          $sformatf("issued %0d expected %0d", n_iss, n));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    int wb_seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state at the ports
    check({iss_vld_o, fwd_vld_o, wb_vld_o, busy_o, done_o} === 5'b0, "R11",
          $sformatf("outputs=%05b expected 00000", {iss_vld_o, fwd_vld_o, wb_vld_o, busy_o, done_o}));
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i], i);
      repeat (2) @(negedge clk);
    end

    // R11: reset in the middle of a divide flushes the pipe
    op_i = 2'd2; vlen_i = 7'd10; mask_i = {64{1'b1}}; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check({iss_vld_o, fwd_vld_o, wb_vld_o, busy_o, done_o} === 5'b0, "R11",
          $sformatf("after mid-op reset outputs=%05b expected 00000", {iss_vld_o, fwd_vld_o, wb_vld_o, busy_o, done_o}));
    wb_seen = 0;
    for (int t = 0; t < 30; t++) begin
      if (wb_vld_o || fwd_vld_o || done_o || busy_o) wb_seen++;
      @(negedge clk);
    end
    check(wb_seen == 0, "R11", $sformatf("activity cycles after reset=%0d expected 0", wb_seen));
    run_vec(VECS[3], 3);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule